// File: doc/BRIEF.md
# Path-Addressed Wormhole Packet Switch

This block is the switching core of a three-port packet router. Every port offers a receive queue for reading and a transmit queue for writing. Each queue entry is a character made of a control flag and an 8-bit value. When a receive queue holds a packet, the core picks that input and makes it the source. It consumes the first byte of the packet as the number of the output port and does not forward that byte. It then copies the remaining characters to the chosen output. The copy stops after the end marker has gone through.

The datapath carries one connection at a time. Packets that arrive on other inputs stay in their queues until the current packet has finished. A sequencer steps through five phases: port reset, idle, source capture, destination capture with header removal, and forwarding. When several inputs are waiting, a rotating priority chooses among them. A packet whose address is unusable is drained from its queue and nothing of it is written to any output.

Top module: `pkt_switch_core`

## Requirements
- R1: The port reset output is high from the first rising edge with `rst` high until the first rising edge with `rst` low. While it is high, no read enable and no write strobe is asserted.
- R2: The first character of a packet is a data character whose value is the output port number. That character is read and dropped. Every following character reaches that output in order, so the packet leaves one character shorter than it arrived.
- R3: An end marker is a character with the control flag set. Value 0 means a normal end and value 1 means an error end. Either kind is forwarded to the output and closes the connection. Data characters with values 0 or 1 and the control flag clear pass through as data.
- R4: A character moves only in a cycle where the source queue is non-empty and the destination queue is not full. Its read enable and write strobe are asserted in that same cycle, so no character is lost or duplicated under any backpressure pattern.
- R5: At most one read enable and at most one write strobe are high in any cycle. A packet on another input starts only after the current packet's end marker has been read.
- R6: When several inputs wait in idle, the source is the first waiting port after the last port served, counting upward and wrapping. After reset, port 0 has the highest priority.
- R7: An address value of 3 or more, or an address equal to the source port, is invalid. The whole packet is then read up to and including its end marker, and nothing is written to any output.
- R8: If the first character of a packet has its control flag set, only that character is read and dropped. Nothing is written, and the core returns to idle.
- R9: With the core idle, the address byte is read at the third rising edge after the receive queue becomes non-empty. The first cargo character is written at the next edge, provided the output is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_empty_i | input | 3 | Receive queue empty, one bit per port |
| rx_rd_o | output | 3 | Receive queue read enable, one bit per port |
| rx_ctrl_i | input | 3 | Control flag of the head character of each receive queue |
| rx_data_i | input | 3x8 | Value of the head character of each receive queue |
| tx_full_i | input | 3 | Transmit queue full, one bit per port |
| tx_wr_o | output | 3 | Transmit queue write strobe, one bit per port |
| tx_ctrl_o | output | 3 | Control flag of the character being written |
| tx_data_o | output | 3x8 | Value of the character being written |
| port_rst_o | output | 1 | Reset request to the ports |

## Verification
A read enable or write strobe is sampled at the rising edge where it takes effect. The address read is due three edges after a queue becomes non-empty in idle: one edge for detection, one for source capture and one for the header read. The first cargo write is due one edge after that. The bench timestamps every read and write at the edge where it happens and compares those stamps with the arithmetic values C+2 and C+3, where C is the cycle in which the stimulus was pushed. For packet content, the bench waits until all receive queues are drained plus a few idle cycles before it compares the captured output streams, so that backpressure stretching does not move any check.

// File: rtl/pkt_sw_pkg.sv
package pkt_sw_pkg;

    localparam int unsigned CHAR_DW = 8;

    typedef struct packed {
        logic               is_ctrl;
        logic [CHAR_DW-1:0] val;
    } sw_char_t;

    typedef enum logic [2:0] {
        CS_RESET,
        CS_IDLE,
        CS_TAKE_SRC,
        CS_TAKE_DST,
        CS_FORWARD
    } cs_e;

    // An address is unusable if it names no port or names the input it came from.
    function automatic logic dest_bad(input logic [CHAR_DW-1:0] addr,
                                      input int unsigned src,
                                      input int unsigned nports);
        return (32'(addr) >= nports) || (32'(addr) == src);
    endfunction

endpackage

// File: rtl/pkt_sw_rr_arb.sv
module pkt_sw_rr_arb #(
    parameter int unsigned NP = 3,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] req,
    input  logic          advance,
    output logic          any_req,
    output logic [IW-1:0] grant
);
    logic [IW-1:0] last_q;
    logic          found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int unsigned k = 1; k <= NP; k++) begin
            int unsigned cand;
            cand = (32'(last_q) + k) % NP;
            if (!found && req[cand]) begin
                grant = IW'(cand);
                found = 1'b1;
            end
        end
    end

    assign any_req = |req;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(NP - 1);
        end else if (advance) begin
            last_q <= grant;
        end
    end

    // R6: the chosen port really is waiting
    assert_grant_waiting_R6: assert property (@(posedge clk) disable iff (rst)
        any_req |-> req[grant]);

endmodule

// File: rtl/pkt_sw_ctrl.sv
module pkt_sw_ctrl
    import pkt_sw_pkg::*;
#(
    parameter int unsigned NP = 3,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_req,
    input  logic [IW-1:0] grant,
    input  logic          sel_empty,
    input  sw_char_t      sel_char,
    input  logic          end_seen,
    output logic          port_rst,
    output logic          arb_adv,
    output logic          hdr_del,
    output logic          fwd_en,
    output logic [IW-1:0] src_q,
    output logic [IW-1:0] dst_q,
    output logic          drop_q
);
    cs_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RESET:    state_d = CS_IDLE;
            CS_IDLE:     if (any_req) state_d = CS_TAKE_SRC;
            CS_TAKE_SRC: state_d = CS_TAKE_DST;
            CS_TAKE_DST: if (!sel_empty) state_d = sel_char.is_ctrl ? CS_IDLE : CS_FORWARD;
            CS_FORWARD:  if (end_seen) state_d = CS_IDLE;
            default:     state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_RESET;
            src_q   <= '0;
            dst_q   <= '0;
            drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CS_TAKE_SRC) begin
                src_q <= grant;
            end
            if (state_q == CS_TAKE_DST && !sel_empty) begin
                dst_q  <= IW'(sel_char.val);
                drop_q <= dest_bad(sel_char.val, 32'(src_q), NP);
            end
        end
    end

    assign port_rst = (state_q == CS_RESET);
    assign arb_adv  = (state_q == CS_TAKE_SRC);
    assign hdr_del  = (state_q == CS_TAKE_DST);
    assign fwd_en   = (state_q == CS_FORWARD);

    // R1: the edge right after a reset edge still shows the port reset
    assert_port_rst_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> port_rst);

    // R5: source register is frozen while a connection is open
    assert_src_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && !end_seen) |=> $stable(src_q));

endmodule

// File: rtl/pkt_sw_xbar.sv
module pkt_sw_xbar
    import pkt_sw_pkg::*;
#(
    parameter int unsigned NP = 3,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] rx_empty,
    input  sw_char_t      rx_char [NP],
    input  logic [NP-1:0] tx_full,
    input  logic [IW-1:0] src,
    input  logic [IW-1:0] dst,
    input  logic          drop,
    input  logic          hdr_del,
    input  logic          fwd_en,
    output logic [NP-1:0] rx_rd,
    output logic [NP-1:0] tx_wr,
    output sw_char_t      out_char,
    output sw_char_t      sel_char,
    output logic          sel_empty,
    output logic          end_seen
);
    logic dst_room;
    logic move;
    logic pass;
    logic rd_any;

    assign sel_char  = rx_char[src];
    assign sel_empty = rx_empty[src];
    assign dst_room  = (32'(dst) < NP) ? !tx_full[dst] : 1'b0;

    assign move     = fwd_en && !sel_empty && (drop || dst_room);
    assign pass     = move && !drop;
    assign rd_any   = (hdr_del && !sel_empty) || move;
    assign end_seen = move && sel_char.is_ctrl;
    assign out_char = sel_char;

    for (genvar p = 0; p < NP; p++) begin : g_port
        assign rx_rd[p] = rd_any && (32'(src) == p);
        assign tx_wr[p] = pass && (32'(dst) == p);
    end

    assert_single_reader_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_rd));

    assert_single_writer_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_wr));

    assert_no_write_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_wr & tx_full) == '0);

    assert_no_read_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_rd & rx_empty) == '0);

endmodule

// File: rtl/pkt_switch_core.sv
module pkt_switch_core
    import pkt_sw_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_PORTS-1:0]                  rx_empty_i,
    output logic [NUM_PORTS-1:0]                  rx_rd_o,
    input  logic [NUM_PORTS-1:0]                  rx_ctrl_i,
    input  logic [NUM_PORTS-1:0][CHAR_DW-1:0]     rx_data_i,
    input  logic [NUM_PORTS-1:0]                  tx_full_i,
    output logic [NUM_PORTS-1:0]                  tx_wr_o,
    output logic [NUM_PORTS-1:0]                  tx_ctrl_o,
    output logic [NUM_PORTS-1:0][CHAR_DW-1:0]     tx_data_o,
    output logic                                  port_rst_o
);
    localparam int unsigned IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    sw_char_t      rx_char [NUM_PORTS];
    sw_char_t      out_char;
    sw_char_t      sel_char;
    logic          sel_empty;
    logic          end_seen;
    logic          any_req;
    logic [IW-1:0] grant;
    logic          arb_adv;
    logic          hdr_del;
    logic          fwd_en;
    logic [IW-1:0] src_q;
    logic [IW-1:0] dst_q;
    logic          drop_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_io
        assign rx_char[p]   = '{is_ctrl: rx_ctrl_i[p], val: rx_data_i[p]};
        assign tx_ctrl_o[p] = out_char.is_ctrl;
        assign tx_data_o[p] = out_char.val;
    end

    pkt_sw_rr_arb #(.NP(NUM_PORTS), .IW(IW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (~rx_empty_i),
        .advance (arb_adv),
        .any_req (any_req),
        .grant   (grant)
    );

    pkt_sw_ctrl #(.NP(NUM_PORTS), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .any_req   (any_req),
        .grant     (grant),
        .sel_empty (sel_empty),
        .sel_char  (sel_char),
        .end_seen  (end_seen),
        .port_rst  (port_rst_o),
        .arb_adv   (arb_adv),
        .hdr_del   (hdr_del),
        .fwd_en    (fwd_en),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .drop_q    (drop_q)
    );

    pkt_sw_xbar #(.NP(NUM_PORTS), .IW(IW)) u_xbar (
        .clk       (clk),
        .rst       (rst),
        .rx_empty  (rx_empty_i),
        .rx_char   (rx_char),
        .tx_full   (tx_full_i),
        .src       (src_q),
        .dst       (dst_q),
        .drop      (drop_q),
        .hdr_del   (hdr_del),
        .fwd_en    (fwd_en),
        .rx_rd     (rx_rd_o),
        .tx_wr     (tx_wr_o),
        .out_char  (out_char),
        .sel_char  (sel_char),
        .sel_empty (sel_empty),
        .end_seen  (end_seen)
    );

    // R4: every write is paired with a read in the same cycle
    assert_write_paired_R4: assert property (@(posedge clk) disable iff (rst)
        (|tx_wr_o) |-> (|rx_rd_o));

    // R7: a discarded packet never reaches an output
    assert_drop_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && drop_q) |-> (tx_wr_o == '0));

    // R1: no traffic while the ports are held in reset
    assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
        port_rst_o |-> (rx_rd_o == '0 && tx_wr_o == '0));

endmodule

// File: tb/pkt_switch_core_bench.sv
`timescale 1ns/1ps
module pkt_switch_core_bench;

    localparam int NP = 3;
    localparam int QD = 4096;

    logic             clk = 1'b0;
    logic             rst;
    logic [NP-1:0]    rx_empty;
    logic [NP-1:0]    rx_rd;
    logic [NP-1:0]    rx_ctrl;
    logic [NP-1:0][7:0] rx_data;
    logic [NP-1:0]    tx_full;
    logic [NP-1:0]    tx_wr;
    logic [NP-1:0]    tx_ctrl;
    logic [NP-1:0][7:0] tx_data;
    logic             port_rst;

    always #2.5 clk = ~clk;

    pkt_switch_core u_pkt_switch_core (
        .clk        (clk),
        .rst        (rst),
        .rx_empty_i (rx_empty),
        .rx_rd_o    (rx_rd),
        .rx_ctrl_i  (rx_ctrl),
        .rx_data_i  (rx_data),
        .tx_full_i  (tx_full),
        .tx_wr_o    (tx_wr),
        .tx_ctrl_o  (tx_ctrl),
        .tx_data_o  (tx_data),
        .port_rst_o (port_rst)
    );

    // receive queue models
    logic [8:0] rxm [NP][QD];
    int         rp [NP];
    int         wp [NP];
    // transmit capture
    logic [8:0] cap  [NP][QD];
    int         wcyc [NP][QD];
    int         cnt  [NP];
    // monitors
    int  cyc = 0;
    logic [NP-1:0] inpkt = '0;
    int  hdr_cyc [NP];
    int  order_log [64];
    int  ocnt = 0;
    int  v_rd_empty = 0, v_wr_full = 0, v_multi = 0, v_wr_nord = 0, v_conn = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic bp_en = 1'b0;
    int  checks = 0, miss = 0;
    bit  done = 0;

    initial begin
        for (int p = 0; p < NP; p++) begin
            rp[p] = 0; wp[p] = 0; cnt[p] = 0; hdr_cyc[p] = 0;
        end
    end

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            rx_empty[p] = (rp[p] == wp[p]);
            rx_ctrl[p]  = rxm[p][rp[p] % QD][8];
            rx_data[p]  = rxm[p][rp[p] % QD][7:0];
            tx_full[p]  = bp_en & lfsr[p*5];
        end
    end

    always @(posedge clk) begin
        cyc  <= cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst) begin
            for (int p = 0; p < NP; p++) begin
                if (rx_rd[p]) begin
                    if (rx_empty[p]) v_rd_empty++;
                    else begin
                        if (!inpkt[p]) begin
                            for (int q = 0; q < NP; q++) if (q != p && inpkt[q]) v_conn++;
                            order_log[ocnt % 64] = p;
                            ocnt++;
                            hdr_cyc[p] = cyc;
                        end
                        inpkt[p] = !rxm[p][rp[p] % QD][8];
                        rp[p] <= rp[p] + 1;
                    end
                end
                if (tx_wr[p]) begin
                    if (tx_full[p]) v_wr_full++;
                    cap[p][cnt[p] % QD]  = {tx_ctrl[p], tx_data[p]};
                    wcyc[p][cnt[p] % QD] = cyc;
                    cnt[p]++;
                end
            end
            if ($countones(rx_rd) > 1 || $countones(tx_wr) > 1) v_multi++;
            if ((|tx_wr) && !(|rx_rd)) v_wr_nord++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, miss);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; miss++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            miss++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int p, input bit c, input int v);
        rxm[p][wp[p] % QD] = {c, 8'(v)};
        wp[p] = wp[p] + 1;
    endtask

    task automatic drain_all();
        int guard = 0;
        while ((rp[0] != wp[0] || rp[1] != wp[1] || rp[2] != wp[2]) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic int pat(input int s, input int a, input int i);
        if (i == 0) return 0;
        if (i == 1) return 1;
        return (s * 37 + a * 11 + i * 5 + 3) & 255;
    endfunction

    // compare one output stream against an expected character list
    task automatic cmp_stream(input int p, input int base, input int n,
                              input logic [8:0] exp [8], input string req);
        int got = cnt[p] - base;
        bit ok = (got == n);
        int bad_a = got, bad_e = n;
        if (ok) begin
            for (int i = 0; i < n; i++) begin
                if (ok && cap[p][(base + i) % QD] !== exp[i]) begin
                    ok = 0;
                    bad_a = int'(cap[p][(base + i) % QD]);
                    bad_e = int'(exp[i]);
                end
            end
        end
        chk(ok, req, $sformatf("port %0d stream", p), bad_a, bad_e);
    endtask

    task automatic run_vec(input int s, input int a, input int len, input int err);
        int b [NP];
        logic [8:0] exp [8];
        bit valid = (a < NP) && (a != s);
        for (int p = 0; p < NP; p++) b[p] = cnt[p];
        push(s, 0, a);
        for (int i = 0; i < len; i++) begin
            push(s, 0, pat(s, a, i));
            exp[i] = {1'b0, 8'(pat(s, a, i))};
        end
        push(s, 1, err);
        exp[len] = {1'b1, 8'(err)};
        for (int i = len + 1; i < 8; i++) exp[i] = '0;
        drain_all();
        for (int p = 0; p < NP; p++) begin
            if (valid && p == a) cmp_stream(p, b[p], len + 1, exp, "R2/R3/R4");
            else cmp_stream(p, b[p], 0, exp, "R7");
        end
        chk(rp[s] == wp[s], "R7", "source queue drained", rp[s], wp[s]);
    endtask

    initial begin
        int c0, b1, b2;
        logic [8:0] e3 [8];
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(port_rst === 1'b1, "R1", "port reset during reset", int'(port_rst), 1);
        chk(rx_rd === '0 && tx_wr === '0, "R1", "strobes during reset", int'({rx_rd, tx_wr}), 0);
        rst = 1'b0;
        #1;
        chk(port_rst === 1'b1, "R1", "port reset before first low edge", int'(port_rst), 1);
        @(negedge clk);
        chk(port_rst === 1'b0, "R1", "port reset after first low edge", int'(port_rst), 0);
        repeat (3) @(negedge clk);

        // R6: three waiting inputs right after reset are served 0,1,2
        push(0, 0, 1); push(0, 0, 8'h21); push(0, 1, 0);
        push(1, 0, 2); push(1, 0, 8'h22); push(1, 1, 0);
        push(2, 0, 0); push(2, 0, 8'h23); push(2, 1, 0);
        drain_all();
        for (int i = 0; i < 3; i++)
            chk(order_log[(ocnt - 3 + i) % 64] == i, "R6", "service order after reset",
                order_log[(ocnt - 3 + i) % 64], i);

        // R6: after serving port 1, order is 2,0,1
        push(1, 0, 0); push(1, 1, 0);
        drain_all();
        push(0, 0, 2); push(0, 1, 0);
        push(1, 0, 2); push(1, 1, 1);
        push(2, 0, 1); push(2, 1, 0);
        drain_all();
        chk(order_log[(ocnt - 3) % 64] == 2, "R6", "rotation first", order_log[(ocnt - 3) % 64], 2);
        chk(order_log[(ocnt - 2) % 64] == 0, "R6", "rotation second", order_log[(ocnt - 2) % 64], 0);
        chk(order_log[(ocnt - 1) % 64] == 1, "R6", "rotation third", order_log[(ocnt - 1) % 64], 1);

        // R9: latency from non-empty to header read and first write
        b1 = cnt[1];
        c0 = cyc;
        push(0, 0, 1); push(0, 0, 8'h5A); push(0, 1, 0);
        drain_all();
        chk(hdr_cyc[0] == c0 + 2, "R9", "header read edge", hdr_cyc[0], c0 + 2);
        chk(wcyc[1][b1 % QD] == c0 + 3, "R9", "first write edge", wcyc[1][b1 % QD], c0 + 3);

        // R8: leading end marker alone is dropped, next packet intact
        b2 = cnt[2];
        b1 = cnt[1];
        push(0, 1, 0);
        push(0, 0, 2); push(0, 0, 8'hC3); push(0, 0, 8'h01); push(0, 1, 1);
        e3[0] = 9'h0C3; e3[1] = 9'h001; e3[2] = 9'h101;
        for (int i = 3; i < 8; i++) e3[i] = '0;
        drain_all();
        cmp_stream(2, b2, 3, e3, "R8");
        cmp_stream(1, b1, 0, e3, "R8");
        b1 = cnt[0];
        push(1, 1, 1);
        drain_all();
        chk(rp[1] == wp[1], "R8", "lone marker consumed", rp[1], wp[1]);
        cmp_stream(0, b1, 0, e3, "R8");

        // sweep: backpressure, source, address, length, end kind
        for (int bp = 0; bp < 2; bp++) begin
            bp_en = bp[0];
            for (int s = 0; s < NP; s++)
                for (int a = 0; a < 5; a++)
                    for (int len = 0; len < 4; len++)
                        for (int err = 0; err < 2; err++)
                            run_vec(s, a, len, err);
        end
        bp_en = 1'b0;

        chk(v_rd_empty == 0, "R4", "reads of empty queue", v_rd_empty, 0);
        chk(v_wr_full == 0, "R4", "writes into full queue", v_wr_full, 0);
        chk(v_wr_nord == 0, "R4", "writes without a read", v_wr_nord, 0);
        chk(v_multi == 0, "R5", "cycles with several strobes", v_multi, 0);
        chk(v_conn == 0, "R5", "overlapping connections", v_conn, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule